// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This unit sits beside the control path of a 32-bit RISC core. It turns an exception request into the architectural side effects of entering a handler. A request carries a vector number, the PC of the instruction that raised it, a flag telling whether that instruction sat in a branch delay slot, and the core's current status word. From these the unit works out the PC to save, copies the status word into a shadow register, and builds the status word that the core must write back. It records the offending address for illegal instructions and emits a one-cycle redirect pulse with the handler address.

A return strobe reverses the entry. The shadow status is handed back with its always-one bit forced high, and fetch is redirected to the saved PC. A trap request does not enter a handler: it raises a one-cycle halt pulse carrying the PC, for a debugger to pick up. Vector numbers the unit does not know raise an error pulse and leave all state alone. Every update lands on the clock edge that samples the request.

Top module: `excp_sequencer`

## Requirements
- R1: After reset, every output is zero: all pulses low, and the saved PC, shadow status, fault address, redirect address, halt PC and status write data all 0.
- R2: For the next-instruction class (syscall 0xC, floating-point 0xD), the saved PC becomes PC+4, or PC unchanged when the delay-slot flag is set.
- R3: For the fault class (bus error 0x2, alignment 0x6, illegal 0x7, range 0xB), the saved PC becomes PC, or PC-4 when the delay-slot flag is set.
- R4: A reset-vector request (0x1) leaves the saved PC unchanged. It still copies status and vectors like any other entry.
- R5: On every entry the shadow status takes the whole incoming status word. The status write pulse carries that word with bit 13 (delay-slot record) replaced by the delay-slot flag.
- R6: On entry the redirect address is the vector number shifted left by 8, plus 0xF0000000 when incoming status bit 14 (high vector base) is 1, or plus 0 otherwise.
- R7: An illegal-instruction request (0x7) loads the fault address register with the request PC. All other requests leave that register unchanged.
- R8: A trap request (0xE) gives a one-cycle halt pulse with the halt PC set to the request PC. It gives no redirect and no status write, and changes no register.
- R9: A return strobe without a request redirects to the saved PC. Its status write pulse carries the shadow status with bit 15 (always-one bit) set to 1.
- R10: Every entry and every return pulses the delay-slot-clear output for one cycle. Traps and unknown vectors do not.
- R11: Any other vector number gives a one-cycle error pulse. It gives no redirect, no halt and no status write, and changes no register.
- R12: Each result appears on the clock edge that samples the request, and each pulse lasts exactly one cycle. A request and a return strobe in the same cycle are resolved in favour of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request strobe |
| req_vec | input | 5 | Exception vector number |
| req_pc | input | 32 | PC of the instruction that raised the request |
| req_dslot | input | 1 | Raising instruction sits in a delay slot |
| sr_in | input | 32 | Current status word of the core |
| rfe | input | 1 | Return-from-exception strobe |
| redir_valid | output | 1 | One-cycle fetch redirect pulse |
| redir_addr | output | 32 | Redirect target |
| sr_wr_valid | output | 1 | One-cycle status write pulse |
| sr_wr_data | output | 32 | Status word to write back |
| nds_clear | output | 1 | Clear pending delay-slot state |
| halt_valid | output | 1 | One-cycle debug halt pulse |
| halt_pc | output | 32 | PC reported with the halt |
| vec_err | output | 1 | One-cycle unknown-vector pulse |
| epcr | output | 32 | Saved exception PC |
| esr | output | 32 | Shadow status register |
| eear | output | 32 | Fault address register |

## Verification
A saved PC that is off by one word shows up on `epcr` one edge after the entry. It shows up again as a wrong redirect target on the next return. A shadow status taken from the wrong cycle only surfaces when a later return hands it back, with bit 15 set, on `sr_wr_data`. So the directed sequences chain entries and returns rather than testing each one alone. A trap or unknown vector that leaks into state is caught by reading the three held registers in the cycle after that request, and again at the following return.

// File: rtl/excp_pkg.sv
package excp_pkg;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_RESET,
    CLS_NEXT,
    CLS_FAULT,
    CLS_TRAP,
    CLS_BAD
  } exc_cls_e;

  localparam int unsigned VEC_RESET   = 1;
  localparam int unsigned VEC_BUS     = 2;
  localparam int unsigned VEC_ALIGN   = 6;
  localparam int unsigned VEC_ILLEGAL = 7;
  localparam int unsigned VEC_RANGE   = 11;
  localparam int unsigned VEC_SYSCALL = 12;
  localparam int unsigned VEC_FPE     = 13;
  localparam int unsigned VEC_TRAP    = 14;

  localparam int unsigned SR_BIT_FO  = 15;
  localparam int unsigned SR_BIT_EPH = 14;
  localparam int unsigned SR_BIT_DSX = 13;

  localparam int unsigned VEC_SHIFT = 8;

endpackage

// File: rtl/excp_classify.sv
module excp_classify
  import excp_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             req_valid,
  input  logic [VEC_W-1:0] req_vec,
  output exc_cls_e         cls,
  output logic             is_illegal
);

  localparam logic [VEC_W-1:0] V_RESET   = VEC_W'(VEC_RESET);
  localparam logic [VEC_W-1:0] V_BUS     = VEC_W'(VEC_BUS);
  localparam logic [VEC_W-1:0] V_ALIGN   = VEC_W'(VEC_ALIGN);
  localparam logic [VEC_W-1:0] V_ILLEGAL = VEC_W'(VEC_ILLEGAL);
  localparam logic [VEC_W-1:0] V_RANGE   = VEC_W'(VEC_RANGE);
  localparam logic [VEC_W-1:0] V_SYSCALL = VEC_W'(VEC_SYSCALL);
  localparam logic [VEC_W-1:0] V_FPE     = VEC_W'(VEC_FPE);
  localparam logic [VEC_W-1:0] V_TRAP    = VEC_W'(VEC_TRAP);

  function automatic exc_cls_e vec_to_class(input logic [VEC_W-1:0] v);
    exc_cls_e c;
    case (v)
      V_RESET:                             c = CLS_RESET;
      V_SYSCALL, V_FPE:                    c = CLS_NEXT;
      V_BUS, V_ALIGN, V_ILLEGAL, V_RANGE:  c = CLS_FAULT;
      V_TRAP:                              c = CLS_TRAP;
      default:                             c = CLS_BAD;
    endcase
    return c;
  endfunction

  always_comb begin
    cls        = req_valid ? vec_to_class(req_vec) : CLS_NONE;
    is_illegal = req_valid && (req_vec == V_ILLEGAL);
  end

endmodule

// File: rtl/excp_target.sv
module excp_target
  import excp_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VEC_W = 5,
  parameter int SR_W  = 32
) (
  input  exc_cls_e         cls,
  input  logic [VEC_W-1:0] req_vec,
  input  logic [XLEN-1:0]  req_pc,
  input  logic             req_dslot,
  input  logic [SR_W-1:0]  sr_in,
  output logic [XLEN-1:0]  epc_next,
  output logic [XLEN-1:0]  handler_addr,
  output logic [SR_W-1:0]  sr_entry
);

  localparam logic [XLEN-1:0] WORD    = XLEN'(4);
  localparam logic [XLEN-1:0] HI_BASE = XLEN'(32'hF000_0000);

  // Move back one instruction word when the raising instruction is in a delay slot.
  function automatic logic [XLEN-1:0] slot_adjust(input logic [XLEN-1:0] pc,
                                                  input logic ds);
    return ds ? (pc - WORD) : pc;
  endfunction

  function automatic logic [XLEN-1:0] saved_pc(input exc_cls_e c,
                                               input logic [XLEN-1:0] pc,
                                               input logic ds);
    logic [XLEN-1:0] base;
    base = (c == CLS_NEXT) ? (pc + WORD) : pc;
    return slot_adjust(base, ds);
  endfunction

  function automatic logic [XLEN-1:0] vector_addr(input logic [VEC_W-1:0] v,
                                                  input logic hi);
    logic [XLEN-1:0] off;
    off = XLEN'(v) << VEC_SHIFT;
    return (hi ? HI_BASE : '0) + off;
  endfunction

  function automatic logic [SR_W-1:0] mark_slot(input logic [SR_W-1:0] sr,
                                                input logic ds);
    logic [SR_W-1:0] r;
    r = sr;
    r[SR_BIT_DSX] = ds;
    return r;
  endfunction

  always_comb begin
    epc_next     = saved_pc(cls, req_pc, req_dslot);
    handler_addr = vector_addr(req_vec, sr_in[SR_BIT_EPH]);
    sr_entry     = mark_slot(sr_in, req_dslot);
  end

endmodule

// File: rtl/excp_sequencer.sv
module excp_sequencer
  import excp_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VEC_W = 5,
  parameter int SR_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VEC_W-1:0] req_vec,
  input  logic [XLEN-1:0]  req_pc,
  input  logic             req_dslot,
  input  logic [SR_W-1:0]  sr_in,
  input  logic             rfe,
  output logic             redir_valid,
  output logic [XLEN-1:0]  redir_addr,
  output logic             sr_wr_valid,
  output logic [SR_W-1:0]  sr_wr_data,
  output logic             nds_clear,
  output logic             halt_valid,
  output logic [XLEN-1:0]  halt_pc,
  output logic             vec_err,
  output logic [XLEN-1:0]  epcr,
  output logic [SR_W-1:0]  esr,
  output logic [XLEN-1:0]  eear
);

  localparam logic [SR_W-1:0] FO_MASK = SR_W'(1) << SR_BIT_FO;

  exc_cls_e        cls;
  logic            is_illegal;
  logic [XLEN-1:0] epc_next;
  logic [XLEN-1:0] handler_addr;
  logic [SR_W-1:0] sr_entry;

  // Named internal events, shared by the state logic and the assertions.
  logic take_entry;
  logic take_reset_vec;
  logic take_trap;
  logic take_bad;
  logic take_rfe;

  excp_classify #(.VEC_W(VEC_W)) u_classify (
    .req_valid  (req_valid),
    .req_vec    (req_vec),
    .cls        (cls),
    .is_illegal (is_illegal)
  );

  excp_target #(.XLEN(XLEN), .VEC_W(VEC_W), .SR_W(SR_W)) u_target (
    .cls          (cls),
    .req_vec      (req_vec),
    .req_pc       (req_pc),
    .req_dslot    (req_dslot),
    .sr_in        (sr_in),
    .epc_next     (epc_next),
    .handler_addr (handler_addr),
    .sr_entry     (sr_entry)
  );

  always_comb begin
    take_entry     = (cls == CLS_RESET) || (cls == CLS_NEXT) || (cls == CLS_FAULT);
    take_reset_vec = (cls == CLS_RESET);
    take_trap      = (cls == CLS_TRAP);
    take_bad       = (cls == CLS_BAD);
    take_rfe       = rfe && !req_valid;
  end

  // One-cycle pulse outputs and their data.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_addr  <= '0;
      sr_wr_valid <= 1'b0;
      sr_wr_data  <= '0;
      nds_clear   <= 1'b0;
      halt_valid  <= 1'b0;
      halt_pc     <= '0;
      vec_err     <= 1'b0;
    end else begin
      redir_valid <= take_entry || take_rfe;
      sr_wr_valid <= take_entry || take_rfe;
      nds_clear   <= take_entry || take_rfe;
      halt_valid  <= take_trap;
      vec_err     <= take_bad;
      if (take_entry) begin
        redir_addr <= handler_addr;
        sr_wr_data <= sr_entry;
      end else if (take_rfe) begin
        redir_addr <= epcr;
        sr_wr_data <= esr | FO_MASK;
      end
      if (take_trap) halt_pc <= req_pc;
    end
  end

  // Held architectural registers.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epcr <= '0;
      esr  <= '0;
      eear <= '0;
    end else begin
      if (take_entry) esr <= sr_in;
      if (take_entry && !take_reset_vec) epcr <= epc_next;
      if (is_illegal) eear <= req_pc;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!redir_valid && !halt_valid && !vec_err && epcr == '0));

  assert_shadow_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_entry |=> (esr == $past(sr_in)) && sr_wr_valid);

  assert_dsx_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_entry |=> sr_wr_data[SR_BIT_DSX] == $past(req_dslot));

  assert_handler_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_entry |=> redir_valid && redir_addr == $past(handler_addr));

  assert_reset_keeps_epc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_reset_vec |=> $stable(epcr));

  assert_trap_no_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> halt_valid && !redir_valid && !sr_wr_valid && $stable(esr) && $stable(epcr));

  assert_bad_no_action_R11: assert property (@(posedge clk) disable iff (!rst_n)
    take_bad |=> vec_err && !redir_valid && !halt_valid && $stable(epcr) && $stable(esr) && $stable(eear));

  assert_rfe_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take_rfe |=> redir_addr == $past(epcr) && sr_wr_data[SR_BIT_FO] && sr_wr_valid);

  assert_nds_with_redirect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    nds_clear |-> redir_valid);

  assert_single_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({redir_valid, halt_valid, vec_err}));

  assert_eear_only_illegal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_illegal) |=> $stable(eear));

endmodule

// File: tb/sim_excp_sequencer.sv
module sim_excp_sequencer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [4:0]  req_vec;
  logic [31:0] req_pc;
  logic        req_dslot;
  logic [31:0] sr_in;
  logic        rfe;
  logic        redir_valid;
  logic [31:0] redir_addr;
  logic        sr_wr_valid;
  logic [31:0] sr_wr_data;
  logic        nds_clear;
  logic        halt_valid;
  logic [31:0] halt_pc;
  logic        vec_err;
  logic [31:0] epcr;
  logic [31:0] esr;
  logic [31:0] eear;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench-side copy of the held registers, built from the requirements.
  logic [31:0] m_epc  = '0;
  logic [31:0] m_esr  = '0;
  logic [31:0] m_eear = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  excp_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
    .req_pc(req_pc), .req_dslot(req_dslot), .sr_in(sr_in), .rfe(rfe),
    .redir_valid(redir_valid), .redir_addr(redir_addr),
    .sr_wr_valid(sr_wr_valid), .sr_wr_data(sr_wr_data),
    .nds_clear(nds_clear), .halt_valid(halt_valid), .halt_pc(halt_pc),
    .vec_err(vec_err), .epcr(epcr), .esr(esr), .eear(eear)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_next(input logic [4:0] v);
    return (v == 5'd12) || (v == 5'd13);
  endfunction

  function automatic bit is_fault(input logic [4:0] v);
    return (v == 5'd2) || (v == 5'd6) || (v == 5'd7) || (v == 5'd11);
  endfunction

  function automatic logic [31:0] exp_saved(input logic [4:0] v, input logic [31:0] pc,
                                            input logic ds, input logic [31:0] old);
    if (is_next(v))  return ds ? pc : pc + 32'd4;
    if (is_fault(v)) return ds ? pc - 32'd4 : pc;
    return old;
  endfunction

  function automatic logic [31:0] exp_target(input logic [4:0] v, input logic [31:0] sr);
    logic [31:0] t;
    t = {19'd0, v, 8'd0};
    if (sr[14]) t = t | 32'hF000_0000;
    return t;
  endfunction

  task automatic idle_inputs();
    req_valid = 1'b0; req_vec = '0; req_pc = '0; req_dslot = 1'b0;
    sr_in = '0; rfe = 1'b0;
  endtask

  // Drive an entry request (optionally with a return strobe) for one cycle and check it.
  task automatic do_entry(input string tag, input logic [4:0] v, input logic [31:0] pc,
                          input logic ds, input logic [31:0] sr, input logic with_rfe);
    logic [31:0] srw;
    @(negedge clk);
    req_valid = 1'b1; req_vec = v; req_pc = pc; req_dslot = ds; sr_in = sr; rfe = with_rfe;
    m_epc = exp_saved(v, pc, ds, m_epc);
    m_esr = sr;
    if (v == 5'd7) m_eear = pc;
    srw = (sr & ~32'h0000_2000) | (ds ? 32'h0000_2000 : 32'h0);
    @(negedge clk);
    idle_inputs();
    chk(tag, "redir_valid", {31'd0, redir_valid}, 32'd1);
    chk(tag, "redir_addr", redir_addr, exp_target(v, sr));
    chk(tag, "epcr", epcr, m_epc);
    chk(tag, "esr", esr, m_esr);
    chk(tag, "eear", eear, m_eear);
    chk(tag, "sr_wr_valid", {31'd0, sr_wr_valid}, 32'd1);
    chk(tag, "sr_wr_data", sr_wr_data, srw);
    chk(tag, "nds_clear (R10)", {31'd0, nds_clear}, 32'd1);
    @(negedge clk);
    chk("R12", "redir pulse width", {31'd0, redir_valid}, 32'd0);
    chk("R12", "nds pulse width", {31'd0, nds_clear}, 32'd0);
  endtask

  task automatic test_reset();
    chk("R1", "redir_valid", {31'd0, redir_valid}, 32'd0);
    chk("R1", "sr_wr_valid", {31'd0, sr_wr_valid}, 32'd0);
    chk("R1", "halt_valid", {31'd0, halt_valid}, 32'd0);
    chk("R1", "vec_err", {31'd0, vec_err}, 32'd0);
    chk("R1", "nds_clear", {31'd0, nds_clear}, 32'd0);
    chk("R1", "epcr", epcr, 32'd0);
    chk("R1", "esr", esr, 32'd0);
    chk("R1", "eear", eear, 32'd0);
    chk("R1", "redir_addr", redir_addr, 32'd0);
    chk("R1", "halt_pc", halt_pc, 32'd0);
  endtask

  task automatic test_next_class();
    do_entry("R2_R5_R6", 5'd12, 32'h0000_1000, 1'b0, 32'h0000_8001, 1'b0);
    do_entry("R2_R5_R6", 5'd13, 32'h0000_2000, 1'b1, 32'h0000_4000, 1'b0);
  endtask

  task automatic test_fault_class();
    do_entry("R3_R7", 5'd2,  32'h0000_3000, 1'b0, 32'h0000_0000, 1'b0);
    do_entry("R3_R7", 5'd6,  32'h0000_3010, 1'b1, 32'h0000_0003, 1'b0);
    do_entry("R3_R7", 5'd11, 32'h0000_3020, 1'b0, 32'h0000_4000, 1'b0);
    do_entry("R3_R7", 5'd7,  32'h0000_4444, 1'b1, 32'h0000_4000, 1'b0);
  endtask

  task automatic test_reset_vector();
    do_entry("R4", 5'd1, 32'h0000_9000, 1'b0, 32'h0000_2000, 1'b0);
  endtask

  task automatic test_trap();
    @(negedge clk);
    req_valid = 1'b1; req_vec = 5'd14; req_pc = 32'h0000_5550; sr_in = 32'h0000_FFFF;
    @(negedge clk);
    idle_inputs();
    chk("R8", "halt_valid", {31'd0, halt_valid}, 32'd1);
    chk("R8", "halt_pc", halt_pc, 32'h0000_5550);
    chk("R8", "redir_valid", {31'd0, redir_valid}, 32'd0);
    chk("R8", "sr_wr_valid", {31'd0, sr_wr_valid}, 32'd0);
    chk("R8", "epcr", epcr, m_epc);
    chk("R8", "esr", esr, m_esr);
    chk("R10", "nds_clear on trap", {31'd0, nds_clear}, 32'd0);
    @(negedge clk);
    chk("R12", "halt pulse width", {31'd0, halt_valid}, 32'd0);
  endtask

  task automatic test_bad_vec(input logic [4:0] v);
    @(negedge clk);
    req_valid = 1'b1; req_vec = v; req_pc = 32'h0000_7777; req_dslot = 1'b1;
    sr_in = 32'h1234_5678;
    @(negedge clk);
    idle_inputs();
    chk("R11", "vec_err", {31'd0, vec_err}, 32'd1);
    chk("R11", "redir_valid", {31'd0, redir_valid}, 32'd0);
    chk("R11", "halt_valid", {31'd0, halt_valid}, 32'd0);
    chk("R11", "sr_wr_valid", {31'd0, sr_wr_valid}, 32'd0);
    chk("R11", "epcr", epcr, m_epc);
    chk("R11", "esr", esr, m_esr);
    chk("R11", "eear", eear, m_eear);
    @(negedge clk);
    chk("R12", "err pulse width", {31'd0, vec_err}, 32'd0);
  endtask

  task automatic test_rfe();
    @(negedge clk);
    rfe = 1'b1;
    @(negedge clk);
    idle_inputs();
    chk("R9", "redir_valid", {31'd0, redir_valid}, 32'd1);
    chk("R9", "redir_addr", redir_addr, m_epc);
    chk("R9", "sr_wr_valid", {31'd0, sr_wr_valid}, 32'd1);
    chk("R9", "sr_wr_data", sr_wr_data, m_esr | 32'h0000_8000);
    chk("R10", "nds_clear on return", {31'd0, nds_clear}, 32'd1);
    @(negedge clk);
    chk("R12", "return pulse width", {31'd0, redir_valid}, 32'd0);
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_next_class();
    test_fault_class();
    test_reset_vector();
    test_trap();
    test_bad_vec(5'd5);
    test_bad_vec(5'd31);
    test_rfe();
    // R12: request and return together; the request wins.
    do_entry("R12", 5'd12, 32'h0000_0100, 1'b0, 32'h0000_0000, 1'b1);
    test_rfe();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R12 watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule